// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block decides, every clock, whether the high-side and the low-side switch of a synchronous buck power stage may be enabled. Its command comes from a controller as a pre-decoded three-level PWM code: low, high or mid-level. Low selects the low-side switch and high selects the high-side switch. A mid-level code that persists past a dwell time turns the whole stage off until the code leaves the mid level.

Switching between the two sides is adaptive. An enable is raised only after a comparator reports that the opposite gate has fallen below its turn-on threshold. A mode input chooses how the low-side period ends. In forced continuous conduction it ends only when PWM goes high. In diode emulation a zero-current comparator ends it early. A minimum low-side on-time protects that cutoff from false triggers, and both switches then stay off until the next PWM high.

All three comparator flags pass through two-flop synchronizers. Time limits are given in nanoseconds and turned into cycle counts from a clock-period parameter.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While `rstN` is low at a clock edge, both enables are low in the following cycle. The block leaves reset in its shutdown state.
- R2: In steady state, a PWM code of 2'b00 (low) gives `loEn`=1, `hiEn`=0, and a code of 2'b01 (high) gives `hiEn`=1, `loEn`=0. Codes 2'b10 and 2'b11 are the mid level.
- R3: On a change to PWM low, `hiEn` drops in the cycle after the code is sampled. `loEn` rises only after the synchronized high-gate-below-threshold flag is seen, which is four cycles after the code when the flag follows one cycle behind the gate. `loEn` stays low for as long as the flag stays clear.
- R4: On a change to PWM high, `loEn` drops in the cycle after the code is sampled. `hiEn` rises only after the synchronized low-gate-below-threshold flag is seen.
- R5: A mid-level code held for MID_DWELL_NS/CLK_PERIOD_NS cycles, rounded up (9 by default), forces both enables low. They stay low while the mid level persists.
- R6: Once the code leaves the mid level, shutdown ends and normal low/high sequencing resumes.
- R7: A mid-level code shorter than the dwell keeps the previous valid level in force. The dwell count restarts only on a fresh mid-level entry.
- R8: In diode emulation (`modeFccm`=0), once the minimum on-time has passed, a synchronized zero-current flag ends `loEn` three cycles after the raw flag rises, even with PWM still low.
- R9: After a diode-emulation cutoff, both enables stay low until the PWM code next goes high. A mid-level code or a continued low code does not restart the low side.
- R10: `loEn` stays high for at least LO_MIN_NS/CLK_PERIOD_NS cycles, rounded up (20 by default). A zero-current flag seen earlier than that is ignored.
- R11: In forced continuous conduction (`modeFccm`=1), the zero-current flag is ignored, and `loEn` ends only on a PWM high or a mid-level shutdown.
- R12: `hiEn` and `loEn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pwmCmd | input | 2 | PWM code: 00 low, 01 high, 1x mid level |
| modeFccm | input | 1 | 1 forced continuous conduction, 0 diode emulation |
| zeroCurFlag | input | 1 | Inductor current near zero (asynchronous) |
| hiGateLowFlag | input | 1 | High-side gate below turn-on threshold (asynchronous) |
| loGateLowFlag | input | 1 | Low-side gate below turn-on threshold (asynchronous) |
| hiEn | output | 1 | High-side switch enable |
| loEn | output | 1 | Low-side switch enable |

## Verification
A wrong sequencer state shows up at the enables in the cycle after the edge that set it. Examples are a premature jump to the on state, a missed shutdown, or a cutoff that never returns. The comparison against the bench's reference therefore catches it within one clock. Faults in the dwell counter or the minimum on-time counter stay hidden until the count limit is reached. They then appear as a shutdown one cycle too early or too late, or as a low-side pulse of the wrong length. Synchronizer faults appear as a shift in the three-to-four cycle delay before an enable rises or a cutoff takes effect.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_SHUT    = 3'd0,
    ST_HI_WAIT = 3'd1,
    ST_HI_ON   = 3'd2,
    ST_LO_WAIT = 3'd3,
    ST_LO_ON   = 3'd4,
    ST_DE_OFF  = 3'd5
  } seqState_t;

  // Datapath to control: conditioned inputs and timer results
  typedef struct packed {
    logic isMid;
    logic midTrip;
    logic effHigh;
    logic hiGateLow;
    logic loGateLow;
    logic zeroCur;
    logic loMinDone;
  } seqStrobe_t;

  // Control to datapath
  typedef struct packed {
    logic loRun;
  } seqCmd_t;

  function automatic int nsToCycles(int ns, int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/buck_seq_datapath.sv
module buck_seq_datapath
  import buck_seq_pkg::*;
#(
  parameter int MID_DWELL_CYC = 9,
  parameter int LO_MIN_CYC    = 20,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmCmd,
  input  logic       hiGateLowRaw,
  input  logic       loGateLowRaw,
  input  logic       zeroCurRaw,
  input  seqCmd_t    cmd,
  output seqStrobe_t strobe
);
  localparam int NUM_FLAGS = 3;
  localparam int MID_W = $clog2(MID_DWELL_CYC + 1);
  localparam int LO_W  = $clog2(LO_MIN_CYC + 1);
  localparam logic [MID_W-1:0] MID_LAST = MID_W'(MID_DWELL_CYC - 1);
  localparam logic [LO_W-1:0]  LO_LAST  = LO_W'(LO_MIN_CYC - 1);

  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] syncFlags;
  logic [MID_W-1:0]     midCnt;
  logic [LO_W-1:0]      loCnt;
  logic                 heldHigh;
  logic                 isMid;

  assign rawFlags = {zeroCurRaw, loGateLowRaw, hiGateLowRaw};
  assign isMid    = pwmCmd[1];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawFlags[i]};
    end
    assign syncFlags[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midCnt   <= '0;
      heldHigh <= 1'b0;
      loCnt    <= '0;
    end else begin
      if (!isMid) begin
        midCnt   <= '0;
        heldHigh <= pwmCmd[0];
      end else if (midCnt != MID_LAST) begin
        midCnt <= midCnt + MID_W'(1);
      end
      if (!cmd.loRun)           loCnt <= '0;
      else if (loCnt != LO_LAST) loCnt <= loCnt + LO_W'(1);
    end
  end

  always_comb begin
    strobe.isMid     = isMid;
    strobe.midTrip   = isMid && (midCnt == MID_LAST);
    strobe.effHigh   = isMid ? heldHigh : pwmCmd[0];
    strobe.hiGateLow = syncFlags[0];
    strobe.loGateLow = syncFlags[1];
    strobe.zeroCur   = syncFlags[2];
    strobe.loMinDone = (loCnt == LO_LAST);
  end

endmodule

// File: rtl/buck_seq_control.sv
module buck_seq_control
  import buck_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeFccm,
  input  seqStrobe_t strobe,
  output seqCmd_t    cmd,
  output logic       hiEn,
  output logic       loEn
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    if (strobe.midTrip) begin
      nextState = ST_SHUT;
    end else begin
      case (state)
        ST_SHUT:
          if (!strobe.isMid) nextState = strobe.effHigh ? ST_HI_WAIT : ST_LO_WAIT;
        ST_HI_WAIT:
          if (!strobe.effHigh)       nextState = ST_LO_WAIT;
          else if (strobe.loGateLow) nextState = ST_HI_ON;
        ST_HI_ON:
          if (!strobe.effHigh) nextState = ST_LO_WAIT;
        ST_LO_WAIT:
          if (strobe.effHigh)        nextState = ST_HI_WAIT;
          else if (strobe.hiGateLow) nextState = ST_LO_ON;
        ST_LO_ON:
          if (strobe.effHigh) nextState = ST_HI_WAIT;
          else if (!modeFccm && strobe.zeroCur && strobe.loMinDone) nextState = ST_DE_OFF;
        ST_DE_OFF:
          if (strobe.effHigh) nextState = ST_HI_WAIT;
        default: nextState = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SHUT;
    else       state <= nextState;
  end

  assign hiEn      = (state == ST_HI_ON);
  assign loEn      = (state == ST_LO_ON);
  assign cmd.loRun = (state == ST_LO_ON);

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
  import buck_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int MID_DWELL_NS  = 175,
  parameter int LO_MIN_NS     = 400,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmCmd,
  input  logic       modeFccm,
  input  logic       zeroCurFlag,
  input  logic       hiGateLowFlag,
  input  logic       loGateLowFlag,
  output logic       hiEn,
  output logic       loEn
);
  localparam int MID_DWELL_CYC = nsToCycles(MID_DWELL_NS, CLK_PERIOD_NS);
  localparam int LO_MIN_CYC    = nsToCycles(LO_MIN_NS, CLK_PERIOD_NS);

  seqStrobe_t strobe;
  seqCmd_t    cmd;

  buck_seq_datapath #(
    .MID_DWELL_CYC(MID_DWELL_CYC),
    .LO_MIN_CYC   (LO_MIN_CYC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pwmCmd      (pwmCmd),
    .hiGateLowRaw(hiGateLowFlag),
    .loGateLowRaw(loGateLowFlag),
    .zeroCurRaw  (zeroCurFlag),
    .cmd         (cmd),
    .strobe      (strobe)
  );

  buck_seq_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .modeFccm(modeFccm),
    .strobe  (strobe),
    .cmd     (cmd),
    .hiEn    (hiEn),
    .loEn    (loEn)
  );

endmodule

// File: rtl/buck_seq_checker.sv
module buck_seq_checker #(
  parameter int MID_DWELL_CYC = 9,
  parameter int LO_MIN_CYC    = 20
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwmCmd,
  input logic       modeFccm,
  input logic       hiEn,
  input logic       loEn,
  input logic       hiGateLowS,
  input logic       loGateLowS
);
  int   midRun;
  int   loRun;
  logic wasReset;

  always_ff @(posedge clk) begin
    wasReset <= !rstN;
    if (!rstN) begin
      midRun <= 0;
      loRun  <= 0;
    end else begin
      midRun <= pwmCmd[1] ? ((midRun < MID_DWELL_CYC) ? midRun + 1 : midRun) : 0;
      loRun  <= loEn ? ((loRun < LO_MIN_CYC) ? loRun + 1 : loRun) : 0;
    end
  end

  // R1: reset leaves both enables low
  always_comb begin
    if (wasReset) p_reset_r1: assert (!hiEn && !loEn);
  end

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(hiEn && loEn));

  p_lo_after_hi_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loEn) |-> $past(hiGateLowS));

  p_hi_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hiEn && pwmCmd == 2'b00) |=> !hiEn);

  p_hi_after_lo_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiEn) |-> $past(loGateLowS));

  p_mid_shutdown_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pwmCmd[1] && midRun >= MID_DWELL_CYC - 1) |=> (!hiEn && !loEn));

  p_lo_min_on_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loEn && pwmCmd == 2'b00 && loRun < LO_MIN_CYC - 1) |=> loEn);

  p_fccm_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (loEn && modeFccm && pwmCmd == 2'b00) |=> loEn);

endmodule

bind buck_gate_sequencer buck_seq_checker #(
  .MID_DWELL_CYC(MID_DWELL_CYC),
  .LO_MIN_CYC   (LO_MIN_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwmCmd    (pwmCmd),
  .modeFccm  (modeFccm),
  .hiEn      (hiEn),
  .loEn      (loEn),
  .hiGateLowS(strobe.hiGateLow),
  .loGateLowS(strobe.loGateLow)
);

// File: tb/buck_gate_sequencer_test.sv
module buck_gate_sequencer_test;
  localparam int PERIOD_NS = 20;
  localparam int DWELL     = (175 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int LOMIN     = (400 + PERIOD_NS - 1) / PERIOD_NS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwmCmd = 2'b00;
  logic       modeFccm = 1'b1;
  logic       zeroCur = 1'b0;
  logic       hiGateLow = 1'b1;
  logic       loGateLow = 1'b1;
  wire        hiEn, loEn;

  always #10 clk = ~clk;

  buck_gate_sequencer uut (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .modeFccm(modeFccm),
    .zeroCurFlag(zeroCur), .hiGateLowFlag(hiGateLow), .loGateLowFlag(loGateLow),
    .hiEn(hiEn), .loEn(loEn)
  );

  int    checks = 0;
  int    fails = 0;
  string phase = "R1";
  bit    compareOn = 1'b0;
  bit    gateEmu = 1'b0;
  bit    hiStuck = 1'b0;

  // Reference model: 0 off, 1 wait-high, 2 high, 3 wait-low, 4 low, 5 cut
  int mState = 0;
  int mMid = 0;
  int mLo = 0;
  bit mHeld = 1'b0;
  bit h1 = 1'b0, h2 = 1'b0, l1 = 1'b0, l2 = 1'b0, z1 = 1'b0, z2 = 1'b0;

  always @(posedge clk) begin
    int nxt;
    bit mid, eff;
    if (!rstN) begin
      mState = 0; mMid = 0; mLo = 0; mHeld = 1'b0;
      h1 = 0; h2 = 0; l1 = 0; l2 = 0; z1 = 0; z2 = 0;
    end else begin
      mid = pwmCmd[1];
      eff = mid ? mHeld : pwmCmd[0];
      nxt = mState;
      if (mid && mMid >= DWELL - 1) nxt = 0;
      else if (mState == 0) begin
        if (!mid) nxt = eff ? 1 : 3;
      end else if (eff) begin
        if (mState == 1) nxt = l2 ? 2 : 1;
        else if (mState != 2) nxt = 1;
      end else begin
        if (mState == 1 || mState == 2) nxt = 3;
        else if (mState == 3 && h2) nxt = 4;
        else if (mState == 4 && !modeFccm && z2 && mLo >= LOMIN - 1) nxt = 5;
      end
      if (mid) mMid = (mMid < DWELL - 1) ? mMid + 1 : mMid;
      else begin mMid = 0; mHeld = pwmCmd[0]; end
      mLo = (mState == 4) ? ((mLo < LOMIN - 1) ? mLo + 1 : mLo) : 0;
      h2 = h1; h1 = hiGateLow;
      l2 = l1; l1 = loGateLow;
      z2 = z1; z1 = zeroCur;
      mState = nxt;
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      checks++;
      if (hiEn !== (mState == 2) || loEn !== (mState == 4)) begin
        fails++;
        $display("FAIL %s model: hi=%0b lo=%0b expected hi=%0b lo=%0b",
                 phase, hiEn, loEn, mState == 2, mState == 4);
      end
      checks++;
      if (hiEn === 1'b1 && loEn === 1'b1) begin
        fails++;
        $display("FAIL R12 overlap: hi=%0b lo=%0b expected not both 1", hiEn, loEn);
      end
    end
  end

  // Gate comparators follow the enables one cycle behind
  initial begin
    forever begin
      @(negedge clk);
      if (gateEmu) begin
        hiGateLow = hiStuck ? 1'b0 : !hiEn;
        loGateLow = !loEn;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectPins(input bit expHi, input bit expLo, input string req);
    checks++;
    if (hiEn !== expHi || loEn !== expLo) begin
      fails++;
      $display("FAIL %s: hi=%0b lo=%0b expected hi=%0b lo=%0b", req, hiEn, loEn, expHi, expLo);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    int loCount;
    tick(3);
    expectPins(1'b0, 1'b0, "R1");
    compareOn = 1'b1;
    rstN = 1'b1;
    gateEmu = 1'b1;
    phase = "R2";
    tick(6);
    expectPins(1'b0, 1'b1, "R2");

    phase = "R4";
    pwmCmd = 2'b01;
    tick(1); expectPins(1'b0, 1'b0, "R4");
    tick(3); expectPins(1'b1, 1'b0, "R4");
    tick(5); expectPins(1'b1, 1'b0, "R2");

    phase = "R3";
    pwmCmd = 2'b00;
    tick(1); expectPins(1'b0, 1'b0, "R3");
    tick(3); expectPins(1'b0, 1'b1, "R3");
    pwmCmd = 2'b01;
    tick(8);
    hiStuck = 1'b1;
    pwmCmd = 2'b00;
    tick(10); expectPins(1'b0, 1'b0, "R3");
    hiStuck = 1'b0;
    tick(5); expectPins(1'b0, 1'b1, "R3");

    phase = "R5";
    pwmCmd = 2'b01;
    tick(8); expectPins(1'b1, 1'b0, "R2");
    pwmCmd = 2'b10;
    tick(DWELL - 1); expectPins(1'b1, 1'b0, "R7");
    tick(1); expectPins(1'b0, 1'b0, "R5");
    tick(10); expectPins(1'b0, 1'b0, "R5");

    phase = "R6";
    pwmCmd = 2'b00;
    tick(2); expectPins(1'b0, 1'b1, "R6");

    phase = "R7";
    for (int k = 0; k < 2; k++) begin
      pwmCmd = 2'b11;
      tick(DWELL - 1); expectPins(1'b0, 1'b1, "R7");
      pwmCmd = 2'b00;
      tick(2); expectPins(1'b0, 1'b1, "R7");
    end

    phase = "R11";
    zeroCur = 1'b1;
    tick(40); expectPins(1'b0, 1'b1, "R11");
    zeroCur = 1'b0;

    phase = "R10";
    modeFccm = 1'b0;
    tick(3);
    pwmCmd = 2'b01;
    tick(8); expectPins(1'b1, 1'b0, "R2");
    zeroCur = 1'b1;
    pwmCmd = 2'b00;
    loCount = 0;
    for (int k = 0; k < 60; k++) begin
      tick(1);
      if (loEn === 1'b1) loCount++;
    end
    checks++;
    if (loCount != LOMIN) begin
      fails++;
      $display("FAIL R10 low-side pulse: %0d cycles expected %0d", loCount, LOMIN);
    end

    phase = "R9";
    expectPins(1'b0, 1'b0, "R9");
    pwmCmd = 2'b10;
    tick(3);
    pwmCmd = 2'b00;
    tick(5); expectPins(1'b0, 1'b0, "R9");
    pwmCmd = 2'b01;
    tick(5); expectPins(1'b1, 1'b0, "R9");

    phase = "R8";
    zeroCur = 1'b0;
    pwmCmd = 2'b00;
    tick(30); expectPins(1'b0, 1'b1, "R8");
    zeroCur = 1'b1;
    tick(2); expectPins(1'b0, 1'b1, "R8");
    tick(1); expectPins(1'b0, 1'b0, "R8");
    tick(5);
    finishRun();
  end

endmodule